// File: doc/BRIEF.md
# System Clock Source Controller

This block chooses which of two free-running clocks drives the system clock of a small microcontroller, and gates that clock. One source is an internal high-speed oscillator. A counter divides it down to five frequency steps. The other source is an external input, which may come from a crystal or from a driven clock; a mode flag records which of the two is in use. Three byte-wide registers on a configuration clock hold the per-source stop bits, the source-select bit and the frequency code. A global stop input halts both sources.

After reset the system clock always comes from the internal oscillator. Its frequency code is loaded from a nonvolatile option input while reset is held, and software may rewrite it later. Changing the source uses a break-before-make handshake: each clock domain has two synchronising flops, and the old source is gated off on its own falling edge before the new one is enabled. A change of frequency code takes effect only where every divider tap is at a period boundary. A status bit reports the source that is actually driving the output, once the handshake has finished.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: While `rst_ni` is low, the select bit, the status bit and `src_ext_o` reset to 0 (internal source). The external stop bit resets to 1 and the internal stop bit to 0. The frequency code loads `opt_div_i`, and an option value above 4 loads code 0. Internal oscillator output is driven after release.
- R2: The frequency code is at address 2, bits 2:0. Code c (0 to 4) gives a system-clock period of 2^(c+1) base-clock periods. A write whose whole byte is above 4 is ignored.
- R3: The select bit is bit 4 of address 1: 0 selects internal and 1 selects external. Bit 5 of address 1 and `src_ext_o` show the source that is actually driving. They change only when the handshake completes. A select write made while a switch is still pending is ignored.
- R4: A select write that targets a source whose stop bit is set is ignored.
- R5: Address 0 holds the external stop bit (bit 7), the external mode flag (bit 6, 1 = driven clock, 0 = crystal) and the internal stop bit (bit 0). A write that would set the stop bit of the selected source, or of the driving source, leaves that bit clear.
- R6: While `stop_i` is high, `sys_clk_o` has no edges. When it drops, the selected source resumes.
- R7: The two source gates are never open at the same time. `sys_clk_o` shows no high or low phase shorter than one base-clock period.
- R8: The divider tap in use changes only at the base-clock edge where the divider counter wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk_i | input | 1 | Configuration register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hosc_base_i | input | 1 | Internal oscillator base clock (twice the top step) |
| xclk_i | input | 1 | External crystal or driven clock |
| stop_i | input | 1 | Global stop request |
| opt_div_i | input | 3 | Option frequency code loaded at reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| sys_clk_o | output | 1 | Gated system clock |
| src_ext_o | output | 1 | 1 when the external source drives the system clock |

## Verification
Every cycle, the assertions check that the two gates are never open together, that no stop bit is set while its source is selected, and that a blocked select write leaves the select bit unchanged. They also check that the status moves only toward the selected source, that the frequency code stays within range, and that the divider tap changes only at a counter wrap. The bench scenarios show the properties that only appear in the clock waveform. These are the measured period for each frequency code and each source, the absence of edges during a global stop, resumption after it, and the minimum phase width across every switch and every code change.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] ADDR_OSC = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_SEL = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_DIV = 2'd2;

  localparam int XSTOP_BIT = 7;
  localparam int XMODE_BIT = 6;
  localparam int HSTOP_BIT = 0;
  localparam int SEL_BIT   = 4;
  localparam int ACT_BIT   = 5;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int W        = 1,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s1_q <= rst_val_i;
          s2_q <= rst_val_i;
        end else begin
          s1_q <= d_i;
          s2_q <= s1_q;
        end
      end
    end else begin : g_pos
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s1_q <= rst_val_i;
          s2_q <= rst_val_i;
        end else begin
          s1_q <= d_i;
          s2_q <= s1_q;
        end
      end
    end
  endgenerate

  assign q_o = s2_q;
endmodule

// File: rtl/scs_div.sv
module scs_div #(
  parameter int MAX_LOG2 = 4,
  parameter int CODE_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] init_code_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_clk_o
);
  localparam int CNT_W = MAX_LOG2 + 1;

  logic [CODE_W-1:0] code_s, code_s_d, sel_q;
  logic [CNT_W-1:0]  cnt_q;

  scs_sync #(.W(CODE_W), .NEG_EDGE(1'b0)) u_code_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (init_code_i),
    .d_i       (code_i),
    .q_o       (code_s)
  );

  // new tap only at the wrap, where every tap is about to fall to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      code_s_d <= init_code_i;
      sel_q    <= init_code_i;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      code_s_d <= code_s;
      if ((&cnt_q) && (code_s == code_s_d)) sel_q <= code_s;
    end
  end

  assign div_clk_o = cnt_q[sel_q];
endmodule

// File: rtl/scs_leg.sv
module scs_leg #(
  parameter bit EN_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic other_en_i,
  output logic en_o,
  output logic other_seen_o,
  output logic gclk_o
);
  logic req_s, other_s, en_q;

  scs_sync #(.W(1), .NEG_EDGE(1'b1)) u_req_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (EN_RST),
    .d_i       (req_i),
    .q_o       (req_s)
  );

  scs_sync #(.W(1), .NEG_EDGE(1'b1)) u_oth_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (!EN_RST),
    .d_i       (other_en_i),
    .q_o       (other_s)
  );

  // gate moves only while this clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= EN_RST;
    else         en_q <= req_s & ~other_s;
  end

  assign en_o         = en_q;
  assign other_seen_o = other_s;
  assign gclk_o       = clk_i & en_q;
endmodule

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl
  import scs_pkg::*;
#(
  parameter int MAX_LOG2 = 4,
  parameter int CODE_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic              cfg_clk_i,
  input  logic              rst_ni,
  input  logic              hosc_base_i,
  input  logic              xclk_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] opt_div_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              sys_clk_o,
  output logic              src_ext_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_LOG2);

  logic [CODE_W-1:0] init_code, code_q;
  logic xstop_q, xmode_q, hstop_q, sel_q, act_q, stop_q;
  logic h_req_q, x_req_q;
  logic div_clk, h_en, x_en, h_saw_x, x_saw_h, h_gclk, x_gclk;
  logic h_en_s, x_en_s, h_saw_x_s, x_saw_h_s;
  logic done_h, done_x, busy;

  assign init_code = (opt_div_i > MAX_CODE) ? '0 : opt_div_i;

  scs_div #(.MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W)) u_div (
    .clk_i       (hosc_base_i),
    .rst_ni      (rst_ni),
    .init_code_i (init_code),
    .code_i      (code_q),
    .div_clk_o   (div_clk)
  );

  scs_leg #(.EN_RST(1'b1)) u_h_leg (
    .clk_i        (div_clk),
    .rst_ni       (rst_ni),
    .req_i        (h_req_q),
    .other_en_i   (x_en),
    .en_o         (h_en),
    .other_seen_o (h_saw_x),
    .gclk_o       (h_gclk)
  );

  scs_leg #(.EN_RST(1'b0)) u_x_leg (
    .clk_i        (xclk_i),
    .rst_ni       (rst_ni),
    .req_i        (x_req_q),
    .other_en_i   (h_en),
    .en_o         (x_en),
    .other_seen_o (x_saw_h),
    .gclk_o       (x_gclk)
  );

  scs_sync #(.W(4), .NEG_EDGE(1'b0)) u_stat_sync (
    .clk_i     (cfg_clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (4'b1001),
    .d_i       ({h_en, x_en, h_saw_x, x_saw_h}),
    .q_o       ({h_en_s, x_en_s, h_saw_x_s, x_saw_h_s})
  );

  // done: target gate open, other closed, and the other leg has seen it
  assign done_h = h_en_s & ~x_en_s & x_saw_h_s;
  assign done_x = x_en_s & ~h_en_s & h_saw_x_s;
  assign busy   = (act_q != sel_q);

  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xstop_q <= 1'b1;
      xmode_q <= 1'b0;
      hstop_q <= 1'b0;
      sel_q   <= 1'b0;
      act_q   <= 1'b0;
      code_q  <= init_code;
      stop_q  <= 1'b0;
      h_req_q <= 1'b1;
      x_req_q <= 1'b0;
    end else begin
      stop_q  <= stop_i;
      h_req_q <= ~sel_q & ~hstop_q & ~stop_q;
      x_req_q <= sel_q & ~xstop_q & ~stop_q;

      if (sel_q && done_x)        act_q <= 1'b1;
      else if (!sel_q && done_h)  act_q <= 1'b0;

      if (we_i) begin
        case (addr_i)
          ADDR_OSC: begin
            xmode_q <= wdata_i[XMODE_BIT];
            if (!(wdata_i[XSTOP_BIT] && (sel_q || act_q)))
              xstop_q <= wdata_i[XSTOP_BIT];
            if (!(wdata_i[HSTOP_BIT] && (!sel_q || !act_q)))
              hstop_q <= wdata_i[HSTOP_BIT];
          end
          ADDR_SEL: begin
            if (!busy && !(wdata_i[SEL_BIT] ? xstop_q : hstop_q))
              sel_q <= wdata_i[SEL_BIT];
          end
          ADDR_DIV: begin
            if (wdata_i <= REG_DW'(MAX_CODE)) code_q <= wdata_i[CODE_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_OSC: begin
        rdata_o[XSTOP_BIT] = xstop_q;
        rdata_o[XMODE_BIT] = xmode_q;
        rdata_o[HSTOP_BIT] = hstop_q;
      end
      ADDR_SEL: begin
        rdata_o[SEL_BIT] = sel_q;
        rdata_o[ACT_BIT] = act_q;
      end
      ADDR_DIV: rdata_o[CODE_W-1:0] = code_q;
      default: ;
    endcase
  end

  assign sys_clk_o = h_gclk | x_gclk;
  assign src_ext_o = act_q;
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 5,
  parameter int MAX_CODE = 4
) (
  input logic              cfg_clk_i,
  input logic              base_clk_i,
  input logic              rst_ni,
  input logic              wr_sel_ext_i,
  input logic              sel_i,
  input logic              act_i,
  input logic              xstop_i,
  input logic              hstop_i,
  input logic [CODE_W-1:0] code_i,
  input logic              h_en_i,
  input logic              x_en_i,
  input logic [CODE_W-1:0] div_sel_i,
  input logic [CNT_W-1:0]  div_cnt_i
);
  assert_one_gate_R7: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    !(h_en_i && x_en_i));

  assert_sel_blocked_R4: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (wr_sel_ext_i && xstop_i && !sel_i) |=> !sel_i);

  assert_ext_not_stopped_R5: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    sel_i |-> !xstop_i);

  assert_int_not_stopped_R5: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    !sel_i |-> !hstop_i);

  assert_status_rise_R3: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    $rose(act_i) |-> sel_i);

  assert_status_fall_R3: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    $fell(act_i) |-> !sel_i);

  assert_code_range_R2: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    code_i <= CODE_W'(MAX_CODE));

  assert_tap_at_wrap_R8: assert property (@(posedge base_clk_i) disable iff (!rst_ni)
    !$stable(div_sel_i) |-> (div_cnt_i == '0));
endmodule

bind sysclk_src_ctrl scs_checker #(
  .CODE_W   (CODE_W),
  .CNT_W    (MAX_LOG2 + 1),
  .MAX_CODE (MAX_LOG2)
) u_scs_checker (
  .cfg_clk_i    (cfg_clk_i),
  .base_clk_i   (hosc_base_i),
  .rst_ni       (rst_ni),
  .wr_sel_ext_i (we_i && (addr_i == scs_pkg::ADDR_SEL) && wdata_i[scs_pkg::SEL_BIT]),
  .sel_i        (sel_q),
  .act_i        (act_q),
  .xstop_i      (xstop_q),
  .hstop_i      (hstop_q),
  .code_i       (code_q),
  .h_en_i       (h_en),
  .x_en_i       (x_en),
  .div_sel_i    (u_div.sel_q),
  .div_cnt_i    (u_div.cnt_q)
);

// File: tb/sysclk_src_ctrl_bench.sv
`timescale 1ns/1ps
module sysclk_src_ctrl_bench;
  import scs_pkg::*;

  localparam int MAX_LOG2 = 4;
  localparam int CODE_W   = 3;

  logic cfg_clk = 1'b0, base_clk = 1'b0, xclk = 1'b0;
  logic rst_n = 1'b0, stop = 1'b0, we = 1'b0;
  logic [CODE_W-1:0] opt = 3'd2;
  logic [REG_AW-1:0] addr = '0;
  logic [REG_DW-1:0] wdata = '0;
  logic [REG_DW-1:0] rdata;
  logic sys_clk, src_ext;

  always #5 cfg_clk  = ~cfg_clk;   // 100 MHz
  always #2 base_clk = ~base_clk;  // 4 ns base
  always #7 xclk     = ~xclk;      // 14 ns external

  sysclk_src_ctrl #(.MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W)) u_sysclk_src_ctrl (
    .cfg_clk_i   (cfg_clk),
    .rst_ni      (rst_n),
    .hosc_base_i (base_clk),
    .xclk_i      (xclk),
    .stop_i      (stop),
    .opt_div_i   (opt),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .sys_clk_o   (sys_clk),
    .src_ext_o   (src_ext)
  );

  typedef struct {
    string       req;
    int unsigned exp;
  } exp_t;

  exp_t        exp_q[$];
  int unsigned obs_val;
  event        obs_ev;
  int          n_cmp = 0, n_bad = 0;
  int          edge_cnt = 0;
  realtime     last_t = 0;
  real         min_w = 1.0e9;
  bit          track = 1'b0;

  // monitor: pops the expectation for each observation
  initial begin
    forever begin
      exp_t e;
      @(obs_ev);
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: observation %0d with no expectation", obs_val);
      end else begin
        e = exp_q.pop_front();
        if (obs_val !== e.exp) begin
          n_bad++;
          $display("FAIL %s: actual %0d expected %0d", e.req, obs_val, e.exp);
        end
      end
    end
  end

  always @(posedge sys_clk) edge_cnt++;

  always @(sys_clk) begin
    if (track && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic push_obs(input string req, input int unsigned exp, input int unsigned val);
    exp_t e;
    e.req = req;
    e.exp = exp;
    exp_q.push_back(e);
    obs_val = val;
    ->obs_ev;
    #1;
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [REG_DW-1:0] d);
    @(negedge cfg_clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge cfg_clk);
    we = 1'b0;
  endtask

  task automatic chk_rd(input logic [REG_AW-1:0] a, input int unsigned exp, input string req);
    @(negedge cfg_clk);
    addr = a;
    #1;
    push_obs(req, exp, rdata);
  endtask

  task automatic chk_src(input int unsigned exp, input string req);
    @(negedge cfg_clk);
    push_obs(req, exp, src_ext);
  endtask

  task automatic chk_period(input int unsigned exp, input string req);
    realtime t0;
    repeat (2) @(posedge sys_clk);
    t0 = $realtime;
    @(posedge sys_clk);
    push_obs(req, exp, int'($realtime - t0));
  endtask

  task automatic settle();
    repeat (300) @(negedge cfg_clk);
  endtask

  task automatic do_reset(input logic [CODE_W-1:0] o);
    track = 1'b0;
    rst_n = 1'b0;
    opt   = o;
    #53;
    rst_n = 1'b1;
    settle();
    track = 1'b1;
  endtask

  initial begin
    int c0;
    do_reset(3'd2);
    // R1 reset state
    chk_rd(ADDR_DIV, 2, "R1 option code");
    chk_rd(ADDR_SEL, 8'h00, "R1 select/status");
    chk_rd(ADDR_OSC, 8'h80, "R1 stop bits");
    chk_src(0, "R1 src_ext_o");
    chk_period(32, "R1 period from option");

    // R2 frequency codes
    wr(ADDR_DIV, 8'd0); settle();
    chk_period(8, "R2 code0");
    wr(ADDR_DIV, 8'd4); settle();
    chk_period(128, "R2 code4");
    wr(ADDR_DIV, 8'd6);
    chk_rd(ADDR_DIV, 4, "R2 invalid code ignored");
    settle();
    chk_period(128, "R2 period kept");
    wr(ADDR_DIV, 8'd1); settle();
    chk_period(16, "R8 code1 after boundary change");

    // R4 select toward stopped external
    wr(ADDR_SEL, 8'h10);
    chk_rd(ADDR_SEL, 8'h00, "R4 select ignored");
    settle();
    chk_period(16, "R4 clock unchanged");

    // R5 clear external stop, set mode flag
    wr(ADDR_OSC, 8'h40);
    chk_rd(ADDR_OSC, 8'h40, "R5 mode flag and stop clear");

    // R3 switch to external
    wr(ADDR_SEL, 8'h10); settle();
    chk_rd(ADDR_SEL, 8'h30, "R3 select and status ext");
    chk_src(1, "R3 src_ext_o");
    chk_period(14, "R3 external period");

    // R5 stop guard on active source
    wr(ADDR_OSC, 8'hC0);
    chk_rd(ADDR_OSC, 8'h40, "R5 ext stop blocked");
    wr(ADDR_OSC, 8'h41);
    chk_rd(ADDR_OSC, 8'h41, "R5 int stop accepted");
    chk_period(14, "R5 clock unaffected");
    wr(ADDR_SEL, 8'h00);
    chk_rd(ADDR_SEL, 8'h30, "R4 select to stopped internal ignored");

    // R3 switch back, status lags
    wr(ADDR_OSC, 8'h40);
    wr(ADDR_SEL, 8'h00);
    chk_rd(ADDR_SEL, 8'h20, "R3 status waits for handshake");
    settle();
    chk_rd(ADDR_SEL, 8'h00, "R3 status internal after handshake");
    chk_src(0, "R3 src_ext_o back");
    chk_period(16, "R3 internal period");

    // R6 global stop
    stop = 1'b1;
    repeat (50) @(negedge cfg_clk);
    c0 = edge_cnt;
    #2000;
    push_obs("R6 no edges during stop", 0, edge_cnt - c0);
    stop = 1'b0;
    settle();
    chk_period(16, "R6 resumes");

    // select external, then reset must return to internal
    wr(ADDR_OSC, 8'h00);
    wr(ADDR_SEL, 8'h10); settle();
    chk_src(1, "R3 external again");
    push_obs("R7 min phase width", 1, (min_w >= 3.99) ? 1 : 0);

    do_reset(3'd7);
    chk_rd(ADDR_DIV, 0, "R1 invalid option gives code0");
    chk_rd(ADDR_SEL, 8'h00, "R1 internal after reset");
    chk_src(0, "R1 src_ext_o after reset");
    chk_period(8, "R1 period after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule